// File: doc/BRIEF.md
# Clock Generator Control Register Slave

This block is a two-wire serial slave that holds the control byte registers of a clock generator. A host addresses it with a write, then always sends one command byte and one byte-count byte. Both are acknowledged and their contents are thrown away. Every data byte after those two lands in the next register, counting from register 0. A read addressed to the block returns the registers from register 0 onward, one byte per acknowledge from the host.

The registers drive a set of control fields: a software frequency selection with its hardware/software switch, a force-all-outputs-off bit, the spread-spectrum controls, three per-output enable masks, two skew codes with two CPU clock enables, and a divider-ratio code. Register 1 also reports five strap inputs, which are captured while reset is held. Two constant identification bytes follow the writable registers. Defaults load only on the power-up reset; bus traffic never restores them. The clock synthesis that uses these fields is outside this block.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: While and after the power-up reset, before any write, the registers read as follows. Reg 0 reads 0x00. Reg 1 reads the strap bits over a low field of 3'b001. Regs 2, 3 and 4 read 0xFF. Reg 5 reads 0x93. Regs 6 to 10 read 0x00. The outputs decode these values, so `ss_center`=1, all enables are 1, both skew codes are 3'b100 and `div_code`=0.
- R2: Only a 7-bit address equal to DEV_ADDR, with R/W as bit 0 of the address byte, is acknowledged. After any other address the block drives nothing and changes no register until the next start.
- R3: After a matching write address, the next two bytes (command and count) are acknowledged and change no register. A transaction that ends after them leaves every output unchanged.
- R4: Each data byte after the count byte is acknowledged and written to register 0, then 1, 2 and onward.
- R5: Reg 0 drives the following fields. `sw_sel[3:0]` comes from bits 7:4, `sw_sel[4]` from bit 2 and `sw_sel[5]` from bit 1. `sw_mode` comes from bit 3 (1 = software select). `out_tristate` comes from bit 0.
- R6: Reg 1 bits 7:3 read back the straps FS0..FS4, with `strap_fs[0]` at bit 7 and `strap_fs[4]` at bit 3. These bits are captured during reset only and ignore writes. Bit 2 drives `ss_narrow`, bit 1 drives `ss_enable` and bit 0 drives `ss_center`.
- R7: Regs 2, 3 and 4 drive `oe_sdram`, `oe_pci` and `oe_aux` bit for bit. In reg 5, bits 7:5 drive `skew_mem`, bits 4:2 drive `skew_66` and bits 1:0 drive `oe_cpu`.
- R8: Bits 6:3 of reg 10 drive `div_code`.
- R9: Reg 11 always reads 0x98 and reg 12 always reads 0x32. Writes to them and to any index above 12 are acknowledged and discarded.
- R10: A matching read address is acknowledged. Bytes are then returned most significant bit first, starting at reg 0, and the index advances after each byte. A host NACK ends the read. Indices above 12 read 0x00.
- R11: A later transaction never reloads defaults. Register values persist across starts and stops, and change only when a data byte is written to their index.
- R12: The data line is released (`sda_oe`=0) whenever the bus is idle and after every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_fs | input | 5 | Frequency strap levels, captured during reset |
| sw_sel | output | 6 | Software frequency selection |
| sw_mode | output | 1 | 1 = software selection, 0 = hardware straps |
| out_tristate | output | 1 | Force all clock outputs off |
| ss_narrow | output | 1 | 1 = 0.25 % spread, 0 = 0.5 % spread |
| ss_enable | output | 1 | Spread spectrum on |
| ss_center | output | 1 | 1 = centre spread, 0 = down spread |
| oe_sdram | output | 8 | Memory clock enables |
| oe_pci | output | 8 | Bus clock enables |
| oe_aux | output | 8 | Auxiliary clock enables |
| oe_cpu | output | 2 | CPU clock enables |
| skew_mem | output | 3 | CPU-to-memory skew code |
| skew_66 | output | 3 | CPU-to-3.3 V clock skew code |
| div_code | output | 4 | Divider-ratio code |

## Verification
The bench builds the block with DEV_ADDR = 7'h2D instead of the default and with three synchronizer stages. This shows that address matching follows the parameter and that the protocol tolerates a longer input latency. With eleven writable registers, a burst of 14 data bytes reaches the two identification bytes and one index past the end. That exercises the discard of read-only and out-of-range writes, and the zero read past the last register, inside a single transaction.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int IDX_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } i2c_st_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_CMD,
      PH_CNT,
      PH_DATA
   } i2c_ph_e;

   // saturating index advance, never wraps back to register 0
   function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] v);
      return (v == '1) ? v : v + IDX_W'(1);
   endfunction

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
   parameter int              WIDTH   = 2,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkctl_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("clkctl_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave
   import clkctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_stb,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_byte,
   output logic             sda_oe
);

   logic       scl_d, sda_d;
   logic       scl_rise, scl_fall, start_c, stop_c;
   i2c_st_e    st;
   i2c_ph_e    ph;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic [6:0] tx_sh;
   logic       is_read, mack_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_ADDR;
         cnt     <= '0;
         sh      <= '0;
         tx_sh   <= '0;
         is_read <= 1'b0;
         mack_ok <= 1'b0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         wr_byte <= '0;
         wr_idx  <= '0;
         rd_idx  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_c) begin
            st     <= ST_RX;
            ph     <= PH_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_c) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (ph == PH_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           st      <= ST_ACK;
                           sda_oe  <= 1'b1;
                           is_read <= sh[0];
                           wr_idx  <= '0;
                           rd_idx  <= '0;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        st     <= ST_ACK;
                        sda_oe <= 1'b1;
                        if (ph == PH_DATA) begin
                           wr_stb  <= 1'b1;
                           wr_byte <= sh;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     unique case (ph)
                        PH_ADDR: begin
                           if (is_read) begin
                              st     <= ST_TX;
                              tx_sh  <= rd_data[6:0];
                              sda_oe <= ~rd_data[7];
                              rd_idx <= idx_next(rd_idx);
                           end else begin
                              st <= ST_RX;
                              ph <= PH_CMD;
                           end
                        end
                        PH_CMD: begin
                           st <= ST_RX;
                           ph <= PH_CNT;
                        end
                        PH_CNT: begin
                           st <= ST_RX;
                           ph <= PH_DATA;
                        end
                        default: begin
                           st     <= ST_RX;
                           wr_idx <= idx_next(wr_idx);
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_MACK;
                     end else begin
                        sda_oe <= ~tx_sh[6];
                        tx_sh  <= {tx_sh[5:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_ok <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_ok) begin
                        st     <= ST_TX;
                        cnt    <= '0;
                        tx_sh  <= rd_data[6:0];
                        sda_oe <= ~rd_data[7];
                        rd_idx <= idx_next(rd_idx);
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R12: an idle slave never holds the data line
   a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R4: every stored data byte is acknowledged in the same bit slot
   a_r4_data_acked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (st == ST_ACK) && sda_oe);

   // R10: the slave only transmits inside a read transaction
   a_r10_tx_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX || st == ST_MACK) |-> is_read);

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int         NUM_RW  = 11,
   parameter logic [7:0] ID_HI   = 8'h98,
   parameter logic [7:0] ID_LO   = 8'h32,
   parameter int         DIV_REG = 10,
   parameter int         DIV_LSB = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       strap_fs,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic [7:0]       ctl_sel,
   output logic [2:0]       ctl_ss,
   output logic [23:0]      mask_flat,
   output logic [7:0]       ctl_skew,
   output logic [3:0]       div_code
);

   localparam int ID_IDX0 = NUM_RW;
   localparam int ID_IDX1 = NUM_RW + 1;

   if (NUM_RW < 11) begin : g_bad_num
      $error("clkctl_regfile: NUM_RW must cover registers 0 to 10");
   end
   if (DIV_REG >= NUM_RW || DIV_LSB > 4) begin : g_bad_div
      $error("clkctl_regfile: divider field out of range");
   end

   function automatic logic [7:0] rst_byte(input int i);
      case (i)
         1:       return 8'h01;
         2, 3, 4: return 8'hFF;
         5:       return 8'h93;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] wr_mask(input int i);
      return (i == 1) ? 8'h07 : 8'hFF;
   endfunction

   logic [4:0]          strap_q;
   logic [7:0]          rw_v [NUM_RW];
   logic [NUM_RW*8-1:0] rw_flat;

   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_fs;
   end

   for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= rst_byte(g);
         else if (wr_en && wr_idx == IDX_W'(g))    q <= wr_data & wr_mask(g);
      end
      assign rw_v[g]            = q;
      assign rw_flat[g*8 +: 8]  = q;
      if (g >= 2 && g <= 4) begin : g_mask
         assign mask_flat[(g-2)*8 +: 8] = q;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_RW; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = rw_v[i];
      end
      if (rd_idx == IDX_W'(1))
         rd_data = (rw_v[1] & 8'h07) |
                   {strap_q[0], strap_q[1], strap_q[2], strap_q[3], strap_q[4], 3'b000};
      if (rd_idx == IDX_W'(ID_IDX0)) rd_data = ID_HI;
      if (rd_idx == IDX_W'(ID_IDX1)) rd_data = ID_LO;
   end

   assign ctl_sel  = rw_v[0];
   assign ctl_ss   = rw_v[1][2:0];
   assign ctl_skew = rw_v[5];
   assign div_code = rw_v[DIV_REG][DIV_LSB +: 4];

   // R9: writes at or beyond the identification index leave all storage alone
   a_r9_ro_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(ID_IDX0)) |=> $stable(rw_flat));

   // R11: without a write strobe nothing is reloaded or altered
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rw_flat));

   // R6: strap capture is frozen once reset is released
   a_r6_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(strap_q));

endmodule

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs
   import clkctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_RW      = 11,
   parameter logic [7:0] ID_HI       = 8'h98,
   parameter logic [7:0] ID_LO       = 8'h32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [4:0] strap_fs,
   output logic [5:0] sw_sel,
   output logic       sw_mode,
   output logic       out_tristate,
   output logic       ss_narrow,
   output logic       ss_enable,
   output logic       ss_center,
   output logic [7:0] oe_sdram,
   output logic [7:0] oe_pci,
   output logic [7:0] oe_aux,
   output logic [1:0] oe_cpu,
   output logic [2:0] skew_mem,
   output logic [2:0] skew_66,
   output logic [3:0] div_code
);

   logic [1:0]       bus_s;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [7:0]       rd_data, wr_byte;
   logic             wr_stb;
   logic [7:0]       ctl_sel, ctl_skew;
   logic [2:0]       ctl_ss;
   logic [23:0]      mask_flat;

   clkctl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (bus_s)
   );

   clkctl_i2c_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (bus_s[1]),
      .sda_s   (bus_s[0]),
      .rd_data (rd_data),
      .rd_idx  (rd_idx),
      .wr_stb  (wr_stb),
      .wr_idx  (wr_idx),
      .wr_byte (wr_byte),
      .sda_oe  (sda_oe)
   );

   clkctl_regfile #(.NUM_RW(NUM_RW), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_fs  (strap_fs),
      .wr_en     (wr_stb),
      .wr_idx    (wr_idx),
      .wr_data   (wr_byte),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .ctl_sel   (ctl_sel),
      .ctl_ss    (ctl_ss),
      .mask_flat (mask_flat),
      .ctl_skew  (ctl_skew),
      .div_code  (div_code)
   );

   // R5 field placement
   assign sw_sel       = {ctl_sel[1], ctl_sel[2], ctl_sel[7:4]};
   assign sw_mode      = ctl_sel[3];
   assign out_tristate = ctl_sel[0];
   // R6 spread controls
   assign ss_narrow    = ctl_ss[2];
   assign ss_enable    = ctl_ss[1];
   assign ss_center    = ctl_ss[0];
   // R7 enables and skews
   assign oe_sdram     = mask_flat[7:0];
   assign oe_pci       = mask_flat[15:8];
   assign oe_aux       = mask_flat[23:16];
   assign skew_mem     = ctl_skew[7:5];
   assign skew_66      = ctl_skew[4:2];
   assign oe_cpu       = ctl_skew[1:0];

endmodule

// File: tb/sim_clkctl_i2c_regs.sv
module sim_clkctl_i2c_regs;

   localparam logic [6:0] DEV = 7'h2D;
   localparam int Q = 6;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_bus;
   logic [4:0] strap = 5'b10110;
   logic sda_oe, sw_mode, out_tristate, ss_narrow, ss_enable, ss_center;
   logic [5:0] sw_sel;
   logic [7:0] oe_sdram, oe_pci, oe_aux;
   logic [1:0] oe_cpu;
   logic [2:0] skew_mem, skew_66;
   logic [3:0] div_code;

   assign sda_bus = sda_m & ~sda_oe;

   clkctl_i2c_regs #(.DEV_ADDR(DEV), .SYNC_STAGES(3)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .strap_fs(strap), .sw_sel(sw_sel), .sw_mode(sw_mode), .out_tristate(out_tristate),
      .ss_narrow(ss_narrow), .ss_enable(ss_enable), .ss_center(ss_center),
      .oe_sdram(oe_sdram), .oe_pci(oe_pci), .oe_aux(oe_aux), .oe_cpu(oe_cpu),
      .skew_mem(skew_mem), .skew_66(skew_66), .div_code(div_code)
   );

   typedef struct packed {
      logic [7:0] b0, b1, b2, b3, b4, b5;
      logic [5:0] sel;
      logic       mode, tri_s;
      logic [2:0] ss, sk_mem, sk_66;
      logic [1:0] cpu;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{8'hA5, 8'h06, 8'h55, 8'hAA, 8'h0F, 8'h5A, 6'h1A, 1'b0, 1'b1, 3'b110, 3'b010, 3'b110, 2'b10},
      '{8'h3A, 8'h01, 8'h00, 8'hFF, 8'h80, 8'hE7, 6'h23, 1'b1, 1'b0, 3'b001, 3'b111, 3'b001, 2'b11},
      '{8'hFE, 8'hFF, 8'h01, 8'h02, 8'h04, 8'h00, 6'h3F, 1'b1, 1'b0, 3'b111, 3'b000, 3'b000, 2'b00},
      '{8'h04, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h93, 6'h10, 1'b0, 1'b0, 3'b000, 3'b100, 3'b100, 2'b11}
   };

   // straps as held during reset, in read-back order FS0 at bit 7
   localparam logic [7:0] STRAP_RB = 8'b0110_1000;

   int n_chk = 0, n_bad = 0;
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(1);
      scl_m = 1'b1; wq(1);
      sda_m = 1'b1; wq(1);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(1);
         scl_m = 1'b1; wq(2);
         scl_m = 1'b0;
      end
      wq(1);
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
      ack = ~sda_bus; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1);
         scl_m = 1'b1; wq(1);
         b[i] = sda_bus; wq(1);
         scl_m = 1'b0;
      end
      wq(1);
      sda_m = ~m_ack; wq(1);
      scl_m = 1'b1; wq(2);
      scl_m = 1'b0; wq(1);
      sda_m = 1'b1;
   endtask

   task automatic write_seq(input logic [6:0] a, input int n, input logic exp_ack, input string tag);
      logic ack;
      bus_start();
      send_byte({a, 1'b0}, ack); chk({tag, " address ack"}, ack, exp_ack);
      send_byte(8'hC3, ack);     chk({tag, " R3 command ack"}, ack, exp_ack);
      send_byte(8'h5C, ack);     chk({tag, " R3 count ack"}, ack, exp_ack);
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ack);
         chk({tag, " R4 data ack"}, ack, exp_ack);
      end
      bus_stop();
      wq(2);
   endtask

   task automatic read_seq(input int n);
      logic ack;
      bus_start();
      send_byte({DEV, 1'b1}, ack); chk("R10 read address ack", ack, 1'b1);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      bus_stop();
      wq(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      strap = 5'b01001;  // later strap changes must not show (R6)

      // R1 reset state at the ports
      chk("R1 sw_sel", sw_sel, 6'h00);
      chk("R1 sw_mode", sw_mode, 1'b0);
      chk("R1 out_tristate", out_tristate, 1'b0);
      chk("R1 spread", {ss_narrow, ss_enable, ss_center}, 3'b001);
      chk("R1 enables", {oe_sdram, oe_pci, oe_aux}, 24'hFFFFFF);
      chk("R1 skews cpu", {skew_mem, skew_66, oe_cpu}, 8'h93);
      chk("R1 div_code", div_code, 4'h0);
      chk("R12 idle release", sda_oe, 1'b0);

      // R1, R6, R9, R10 reset read-back through the bus
      read_seq(14);
      for (int i = 0; i < 14; i++) begin
         logic [7:0] e;
         case (i)
            1:       e = STRAP_RB | 8'h01;
            2, 3, 4: e = 8'hFF;
            5:       e = 8'h93;
            11:      e = 8'h98;
            12:      e = 8'h32;
            default: e = 8'h00;
         endcase
         chk($sformatf("R1 R10 reset readback reg%0d", i), rbuf[i], e);
      end

      // table of writes with expected field decode (R4 R5 R6 R7)
      for (int v = 0; v < 4; v++) begin
         wbuf[0] = VECS[v].b0; wbuf[1] = VECS[v].b1; wbuf[2] = VECS[v].b2;
         wbuf[3] = VECS[v].b3; wbuf[4] = VECS[v].b4; wbuf[5] = VECS[v].b5;
         write_seq(DEV, 6, 1'b1, $sformatf("vec%0d", v));
         chk("R5 sw_sel", sw_sel, VECS[v].sel);
         chk("R5 sw_mode", sw_mode, VECS[v].mode);
         chk("R5 out_tristate", out_tristate, VECS[v].tri_s);
         chk("R6 spread", {ss_narrow, ss_enable, ss_center}, VECS[v].ss);
         chk("R7 oe_sdram", oe_sdram, VECS[v].b2);
         chk("R7 oe_pci", oe_pci, VECS[v].b3);
         chk("R7 oe_aux", oe_aux, VECS[v].b4);
         chk("R7 skew_mem", skew_mem, VECS[v].sk_mem);
         chk("R7 skew_66", skew_66, VECS[v].sk_66);
         chk("R7 oe_cpu", oe_cpu, VECS[v].cpu);
         read_seq(6);
         chk("R10 readback reg0", rbuf[0], VECS[v].b0);
         chk("R6 readback reg1 straps", rbuf[1], STRAP_RB | (VECS[v].b1 & 8'h07));
         chk("R10 readback reg5", rbuf[5], VECS[v].b5);
      end

      // R3 R11: header-only write changes nothing
      write_seq(DEV, 0, 1'b1, "hdr");
      chk("R3 R11 sw_sel held", sw_sel, 6'h10);
      chk("R3 R11 skews held", {skew_mem, skew_66, oe_cpu}, 8'h93);
      chk("R3 R11 oe_pci held", oe_pci, 8'hFF);
      chk("R12 release after stop", sda_oe, 1'b0);

      // R2: foreign address is not acknowledged and not stored
      for (int i = 0; i < 6; i++) wbuf[i] = 8'hFF;
      write_seq(7'h2A, 6, 1'b0, "R2");
      chk("R2 sw_sel untouched", sw_sel, 6'h10);
      chk("R2 tristate untouched", out_tristate, 1'b0);
      chk("R2 oe_cpu untouched", oe_cpu, 2'b11);

      // R8 R9: long burst across id registers and past the end
      wbuf[0] = 8'h00; wbuf[1] = 8'h01; wbuf[2] = 8'hFF; wbuf[3] = 8'hFF;
      wbuf[4] = 8'hFF; wbuf[5] = 8'h93; wbuf[6] = 8'h11; wbuf[7] = 8'h22;
      wbuf[8] = 8'h33; wbuf[9] = 8'h44; wbuf[10] = 8'h58; wbuf[11] = 8'h00;
      wbuf[12] = 8'h00; wbuf[13] = 8'h55;
      write_seq(DEV, 14, 1'b1, "R9 burst");
      chk("R8 div_code", div_code, 4'hB);
      read_seq(15);
      chk("R4 reg6", rbuf[6], 8'h11);
      chk("R4 reg9", rbuf[9], 8'h44);
      chk("R8 reg10", rbuf[10], 8'h58);
      chk("R9 reg11 id", rbuf[11], 8'h98);
      chk("R9 reg12 id", rbuf[12], 8'h32);
      chk("R10 reg13 past end", rbuf[13], 8'h00);
      chk("R10 reg14 past end", rbuf[14], 8'h00);

      // R10: a new read restarts at register 0
      read_seq(2);
      chk("R10 restart reg0", rbuf[0], 8'h00);
      chk("R10 restart reg1", rbuf[1], STRAP_RB | 8'h01);
      chk("R12 release after read", sda_oe, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule